// File: doc/BRIEF.md
# Per-Channel ADC Trigger Controller

This block sits between a register port and a sixteen-channel auxiliary converter. Software starts a conversion on a channel in two steps. It first writes that channel's trigger bit to 0, which withdraws the channel's previous result. It then writes the bit to 1, and that rising transition queues a conversion. The controller serves queued channels one at a time, lowest channel number first. For each one it issues a single-cycle start strobe with the channel number, then waits for the converter's done flag. It stores the returned 12-bit sample and raises that channel's ready flag.

A status register reports busy while any request is queued or a conversion is in flight. Software polls it and then reads the per-channel result registers. The whole controller runs under an external module clock enable. While the enable is closed, register writes have no effect, no conversion is launched and queued requests are held. Work resumes when the enable is reopened. Register reads are answered at all times.

Register map, with `reg_addr` 5 bits wide:
- 0: trigger control. Bit n belongs to channel n.
- 1: status. Bit 0 is busy.
- 16+n: result of channel n. The sample is in bits [11:0] and the ready flag is in bit 12.

Top module: `adc_trig_top`

## Requirements
- R1: After reset, the control, status and all sixteen result registers read 0, and `conv_start` is low.
- R2: A write to address 0 in which a bit goes from 0 to 1 queues one conversion for that channel. Writing 1 to a bit that already holds 1 queues nothing. Each launch is a single-cycle `conv_start` pulse with `conv_chan` equal to the channel.
- R3: When `conv_done` is seen high while a conversion is in flight, `conv_sample` is stored in bits [11:0] of that channel's result register, and its bit 12 (ready) is set to 1.
- R4: A control write that has bit n equal to 0 clears channel n's ready flag. The stored sample bits stay unchanged.
- R5: Requests queued at the same time are launched in ascending channel order. A new launch happens only after the previous conversion's done has been accepted.
- R6: Status bit 0 reads 1 from the cycle after a triggering write until the last queued conversion has been stored. Otherwise it reads 0.
- R7: Result registers read 0 in bits 31:13, and writes to result addresses change nothing.
- R8: While `mod_clk_en` is low, writes are ignored, no launch is made and `conv_done` is not accepted. Queued requests are kept and launched after the enable returns high.
- R9: `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk_en | input | 1 | Module clock enable from the gating register |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 4 | Channel being converted |
| conv_sample | input | 12 | Sample from the converter |
| conv_done | input | 1 | Sample valid; held by the converter until accepted while enabled |

## Verification
The bench aims at several behaviours, and each has a typical fault:
- **Multi-bit trigger writes.** A controller with wrong priority logic would launch the channels out of ascending order, or launch two of them back to back without waiting for done.
- **Rewriting a bit already at 1.** A controller that triggers on level instead of on the 0-to-1 transition would start a spurious conversion.
- **Clearing writes.** A wrong design would either leave the ready flag standing or wipe the stored sample as well.
- **Closing the enable at random points, before launch and during a conversion.** A controller that ignored the enable would launch while gated. One that dropped its queue would leave channels without a result.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_ctrl,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] launch_mask,
  output logic [NUM_CH-1:0] ctrl_q,
  output logic [NUM_CH-1:0] pending_q,
  output logic [NUM_CH-1:0] clr_ready
);
  logic              wr_live;
  logic [NUM_CH-1:0] rise;

  assign wr_live   = en && wr_ctrl;
  assign rise      = wr_live ? (wdata & ~ctrl_q) : '0;
  assign clr_ready = wr_live ? ~wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      pending_q <= '0;
    end else if (en) begin
      if (wr_ctrl) ctrl_q <= wdata;
      pending_q <= (pending_q & ~launch_mask) | rise;
    end
  end

  // a request can only appear through an enabled control write
  assert_pending_source_R2: assert property (@(posedge clk) disable iff (rst)
    ((pending_q & ~$past(pending_q)) != '0) |-> $past(en && wr_ctrl));

  // while gated the queue is frozen
  assert_gated_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (pending_q == $past(pending_q)));
endmodule

// File: rtl/adc_trig_arb.sv
module adc_trig_arb #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [CH_W-1:0]   idx,
  output logic [NUM_CH-1:0] grant
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = CH_W'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              any,
  input  logic [CH_W-1:0]   idx,
  input  logic [NUM_CH-1:0] grant,
  input  logic              done,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic [NUM_CH-1:0] launch_mask,
  output logic              store_we,
  output logic              in_flight
);
  seq_state_e state;
  logic       launch;

  assign launch      = en && any && (state == SEQ_IDLE);
  assign launch_mask = launch ? grant : '0;
  assign store_we    = en && done && (state == SEQ_WAIT);
  assign in_flight   = (state == SEQ_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= launch;
      if (launch) begin
        conv_chan <= idx;
        state     <= SEQ_WAIT;
      end else if (store_we) begin
        state <= SEQ_IDLE;
      end
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_start_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> $past(en));

  assert_one_in_flight_R5: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_WAIT && !store_we) |=> !conv_start);

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/adc_trig_regfile.sv
module adc_trig_regfile
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int CH_W     = 4,
  parameter int ADDR_W   = 5,
  parameter int SAMPLE_W = 12,
  parameter int REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_we,
  input  logic [CH_W-1:0]     set_idx,
  input  logic [SAMPLE_W-1:0] set_sample,
  input  logic [NUM_CH-1:0]   clr_mask,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_CH-1:0]   ctrl_q,
  input  logic                busy,
  output logic [REG_W-1:0]    rdata
);
  logic [SAMPLE_W-1:0] sample_q [NUM_CH];
  logic [NUM_CH-1:0]   ready_q;
  logic [REG_W-1:0]    rd_next;
  logic [CH_W-1:0]     rd_ch;

  assign rd_ch = rd_addr[CH_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        sample_q[g] <= '0;
        ready_q[g]  <= 1'b0;
      end else if (set_we && set_idx == CH_W'(g)) begin
        sample_q[g] <= set_sample;
        ready_q[g]  <= 1'b1;
      end else if (clr_mask[g]) begin
        ready_q[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr[ADDR_W-1]) begin
      rd_next[SAMPLE_W-1:0] = sample_q[rd_ch];
      rd_next[SAMPLE_W]     = ready_q[rd_ch];
    end else if (rd_addr == ADDR_W'(CTRL_OFS)) begin
      rd_next[NUM_CH-1:0] = ctrl_q;
    end else if (rd_addr == ADDR_W'(STAT_OFS)) begin
      rd_next[0] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assert_ready_source_R3: assert property (@(posedge clk) disable iff (rst)
    ((ready_q & ~$past(ready_q)) != '0) |-> $past(set_we));

  assert_ready_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ((~ready_q & $past(ready_q)) != '0) |-> ($past(clr_mask) != '0));
endmodule

// File: rtl/adc_trig_top.sv
module adc_trig_top
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 12,
  parameter int REG_W    = 32,
  parameter int CH_W     = $clog2(NUM_CH),
  parameter int ADDR_W   = CH_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mod_clk_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                conv_start,
  output logic [CH_W-1:0]     conv_chan,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic                conv_done
);
  logic              wr_ctrl;
  logic [NUM_CH-1:0] ctrl_q, pending_q, clr_ready, launch_mask, grant;
  logic              any, store_we, in_flight, busy;
  logic [CH_W-1:0]   idx;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
  assign busy    = any || in_flight;

  adc_trig_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .en(mod_clk_en), .wr_ctrl(wr_ctrl),
    .wdata(reg_wdata[NUM_CH-1:0]), .launch_mask(launch_mask),
    .ctrl_q(ctrl_q), .pending_q(pending_q), .clr_ready(clr_ready)
  );

  adc_trig_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .req(pending_q), .any(any), .idx(idx), .grant(grant)
  );

  adc_trig_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .en(mod_clk_en), .any(any), .idx(idx),
    .grant(grant), .done(conv_done), .conv_start(conv_start),
    .conv_chan(conv_chan), .launch_mask(launch_mask),
    .store_we(store_we), .in_flight(in_flight)
  );

  adc_trig_regfile #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W),
    .SAMPLE_W(SAMPLE_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .set_we(store_we), .set_idx(conv_chan),
    .set_sample(conv_sample), .clr_mask(clr_ready), .rd_addr(reg_addr),
    .ctrl_q(ctrl_q), .busy(busy), .rdata(reg_rdata)
  );
endmodule

// File: tb/sim_adc_trig_top.sv
module sim_adc_trig_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_clk_en = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [11:0] conv_sample;
  logic        conv_done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  adc_trig_top u0 (
    .clk(clk), .rst(rst), .mod_clk_en(mod_clk_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_sample(conv_sample), .conv_done(conv_done)
  );

  // converter model: latency counts only while enabled, done held until accepted
  logic [11:0] model_val [16] = '{default: 12'h000};
  int          log_ch [0:1023];
  int          log_n = 0;
  logic        m_busy;
  int          m_cnt;
  logic [3:0]  m_ch;

  always @(posedge clk) begin
    if (rst) begin
      m_busy      <= 1'b0;
      conv_done   <= 1'b0;
      conv_sample <= '0;
      m_cnt       <= 0;
      m_ch        <= '0;
    end else begin
      if (conv_done && mod_clk_en) conv_done <= 1'b0;
      if (conv_start) begin
        m_busy <= 1'b1;
        m_cnt  <= 3 + int'($urandom % 10);
        m_ch   <= conv_chan;
        if (log_n < 1024) log_ch[log_n] <= int'(conv_chan);
        log_n  <= log_n + 1;
      end else if (m_busy && mod_clk_en) begin
        if (m_cnt <= 1) begin
          logic [11:0] v;
          v = 12'($urandom);
          m_busy            <= 1'b0;
          conv_done         <= 1'b1;
          conv_sample       <= v;
          model_val[m_ch]   <= v;
        end else begin
          m_cnt <= m_cnt - 1;
        end
      end
    end
  end

  logic [15:0] exp_ctrl  = '0;
  logic [15:0] exp_ready = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_data(input int ch);
    return {19'b0, exp_ready[ch], model_val[ch]};
  endfunction

  // control write as software sees it (enable open)
  task automatic ctrl_write(input logic [15:0] m, output logic [15:0] rise);
    rise      = m & ~exp_ctrl;
    exp_ready = exp_ready & m;
    exp_ctrl  = m;
    do_write(5'd0, {16'b0, m});
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    do begin
      do_read(5'd1, s);
      n++;
    end while (s[0] && n < 3000);
    chk(req, {31'b0, s[0]}, 32'd0);
  endtask

  task automatic check_order(input int base, input logic [15:0] rise, input string req);
    int k = 0;
    for (int ch = 0; ch < 16; ch++) begin
      if (rise[ch]) begin
        chk(req, 32'(log_ch[base + k]), 32'(ch));
        k++;
      end
    end
    chk(req, 32'(log_n - base), 32'($countones(rise)));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      compared++;
      mismatched++;
      $display("FAIL R8 watchdog expired actual=hang expected=idle");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] rise;
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 start", {31'b0, conv_start}, 32'd0);
    do_read(5'd0, d);  chk("R1 ctrl", d, 32'd0);
    do_read(5'd1, d);  chk("R1 status", d, 32'd0);
    do_read(5'd16, d); chk("R1 data0", d, 32'd0);
    do_read(5'd31, d); chk("R1 data15", d, 32'd0);

    // R2 R3 R6 R9: single trigger on channel 3
    base = log_n;
    ctrl_write(16'h0008, rise);
    do_read(5'd1, d); chk("R6 busy after trigger", d, 32'd1);
    wait_idle("R6 idle");
    exp_ready[3] = 1'b1;
    check_order(base, rise, "R2 single launch");
    do_read(5'd19, d); chk("R3 data3", d, exp_data(3));
    do_read(5'd0, d);  chk("R9 ctrl readback", d, 32'h8);

    // R2: rewriting a set bit starts nothing
    base = log_n;
    ctrl_write(16'h0008, rise);
    repeat (20) @(negedge clk);
    chk("R2 no relaunch", 32'(log_n - base), 32'd0);
    do_read(5'd19, d); chk("R2 ready kept", d, exp_data(3));

    // R4: clearing withdraws ready, keeps sample
    ctrl_write(16'h0000, rise);
    do_read(5'd19, d); chk("R4 ready cleared", d, exp_data(3));
    chk("R4 sample kept", {20'b0, d[11:0]}, {20'b0, model_val[3]});

    // R5: several channels at once
    base = log_n;
    ctrl_write(16'hA005, rise);
    wait_idle("R6 idle multi");
    for (int ch = 0; ch < 16; ch++) if (rise[ch]) exp_ready[ch] = 1'b1;
    check_order(base, rise, "R5 ascending");
    do_read(5'd29, d); chk("R3 data13", d, exp_data(13));

    // R7: writes to result registers are ignored
    do_write(5'd18, 32'hFFFF_FFFF);
    do_read(5'd18, d); chk("R7 data2 unchanged", d, exp_data(2));
    chk("R7 upper zero", {13'b0, d[31:13]}, 32'd0);

    // R8: gated writes ignored, held request resumes
    mod_clk_en = 1'b0;
    do_write(5'd0, 32'h0000_0100);
    do_read(5'd0, d); chk("R8 gated write ignored", d, {16'b0, exp_ctrl});
    mod_clk_en = 1'b1;
    ctrl_write(16'h0000, rise);
    base = log_n;
    @(negedge clk);
    reg_addr = 5'd0; reg_wdata = 32'h0000_0014; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; mod_clk_en = 1'b0;
    rise = 16'h0014 & ~exp_ctrl; exp_ready = exp_ready & 16'h0014; exp_ctrl = 16'h0014;
    repeat (40) @(negedge clk);
    chk("R8 no launch while gated", 32'(log_n - base), 32'd0);
    do_read(5'd1, d); chk("R8 busy held", d, 32'd1);
    mod_clk_en = 1'b1;
    wait_idle("R8 idle after resume");
    for (int ch = 0; ch < 16; ch++) if (rise[ch]) exp_ready[ch] = 1'b1;
    check_order(base, rise, "R8 resumed order");

    // random phase: mixed masks and enable drops
    for (int it = 0; it < 30; it++) begin
      logic [15:0] m;
      m = 16'($urandom);
      base = log_n;
      ctrl_write(m, rise);
      if ($urandom % 2 == 1) begin
        repeat ($urandom % 9) @(negedge clk);
        mod_clk_en = 1'b0;
        repeat (1 + $urandom % 30) @(negedge clk);
        mod_clk_en = 1'b1;
      end
      wait_idle("R6 idle random");
      for (int ch = 0; ch < 16; ch++) if (rise[ch]) exp_ready[ch] = 1'b1;
      check_order(base, rise, "R5 random order");
      for (int k = 0; k < 4; k++) begin
        int ch;
        ch = int'($urandom % 16);
        do_read(5'(16 + ch), d);
        chk("R3 R4 random data", d, exp_data(ch));
      end
    end

    finish_run();
  end
endmodule